// File: doc/BRIEF.md
# Bus Slave Control Register Bank with Broadcast Class Match

This block holds the control and status registers of a slave card on a shared backplane bus. It has four registers: a general control word, a logical-address word, a block-transfer word counter and a broadcast-class enable mask. Host software reaches all four through a single register write port and a combinational read port.

Two events come from outside the register port. A per-word decrement strobe counts down the word counter during a block readout. A load-next-event strobe refills the counter with the word count of the next event. A broadcast request carries a 3-bit class number. The block raises a registered selected flag when the mask enables that class. Only classes 0 to 3 can match.

The registers sit in two reset domains. The power-up reset (`rst_n`) clears everything. The master-reset strobe restores only the control word and the word counter. It leaves the logical address and the broadcast mask unchanged.

Top module: `bus_slave_csr`

## Requirements
- R1: Register select 1 is the logical address. Bits 31:16 of a write are stored. Bits 15:0 are ignored on write and always read back as zero.
- R2: The logical address clears to zero only on power-up reset. A master-reset strobe leaves it unchanged.
- R3: Register select 2 is the word counter, 7 bits wide at bits 6:0. A write loads bits 6:0, and bits 31:7 read back as zero. `word_count_o` always shows the counter value.
- R4: A load-next-event strobe loads the counter from `evt_count_i` on the next clock edge. This load wins over a decrement and over a register write in the same cycle.
- R5: Each decrement strobe lowers the counter by one. The counter holds at zero and does not wrap. `count_zero_o` is high exactly when the counter is zero.
- R6: A master-reset strobe clears the counter to zero. This clear wins over a load, a write and a decrement in the same cycle.
- R7: Register select 3 is the broadcast mask, 4 bits wide at bits 3:0. Bits 31:4 are ignored on write and read back as zero. One cycle after a broadcast request for class N (N < 4), `bcast_sel_o` is high exactly when mask bit N is set. With no request it is low.
- R8: A broadcast request for class 4, 5, 6 or 7 never raises `bcast_sel_o`, whatever the mask holds.
- R9: The broadcast mask clears to zero only on power-up reset. A master-reset strobe leaves it unchanged.
- R10: Register select 0 is the control word. It is fully writable and holds 0x00000040 after power-up reset and after every master-reset strobe. A master reset overrides a write to it in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| mrst_i | input | 1 | Master-reset strobe, synchronous |
| wr_en_i | input | 1 | Register write enable |
| reg_sel_i | input | 2 | Register select for read and write |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Read data for the selected register |
| xfer_dec_i | input | 1 | One word transferred: decrement counter |
| evt_load_i | input | 1 | Load-next-event strobe |
| evt_count_i | input | 7 | Word count of the next event |
| bcast_req_i | input | 1 | Broadcast request |
| bcast_class_i | input | 3 | Broadcast class number |
| word_count_o | output | 7 | Current word counter value |
| count_zero_o | output | 1 | Counter is zero |
| bcast_sel_o | output | 1 | Registered broadcast-selected flag |

## Verification
The bench builds the block with its default parameters: a 7-bit counter, a 4-class mask, a 3-bit class number and a registered selection output. With these values the counter reaches both ends of its range (0x7F and zero) in a few directed writes and strobes. The 3-bit class field can carry every class from 0 to 7, so the bench can show that classes 4 to 7 are rejected while classes 0 to 3 follow the mask. Because the selection output is registered, each broadcast check samples one cycle after the request.

// File: rtl/bus_slave_csr_pkg.sv
package bus_slave_csr_pkg;
   localparam int SEL_W = 2;
   typedef enum logic [SEL_W-1:0] {
      SEL_CTRL  = 2'd0,
      SEL_ADDR  = 2'd1,
      SEL_COUNT = 2'd2,
      SEL_MASK  = 2'd3
   } csr_sel_e;
endpackage

// File: rtl/csr_field_reg.sv
// Generic register field with a per-bit write mask.
// CLR_ON_MRST picks whether the master-reset strobe restores RST_VAL.
module csr_field_reg #(
   parameter int          W           = 32,
   parameter logic [W-1:0] RST_VAL    = '0,
   parameter logic [W-1:0] WMASK      = '1,
   parameter bit          CLR_ON_MRST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         mrst_i,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] nxt;

   always_comb begin
      nxt = q_o;
      if (wr_i) nxt = (wdata_i & WMASK) | (q_o & ~WMASK);
   end

   generate
      if (CLR_ON_MRST) begin : g_mrst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q_o <= RST_VAL;
            else if (mrst_i) q_o <= RST_VAL;
            else             q_o <= nxt;
         end
      end else begin : g_keep
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_o <= RST_VAL;
            else        q_o <= nxt;
         end
      end
   endgenerate
endmodule

// File: rtl/csr_wcount.sv
// Block-transfer word counter: clear > load > write > saturating decrement.
module csr_wcount #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mrst_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             wr_i,
   input  logic [CNT_W-1:0] wr_val_i,
   input  logic             dec_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             zero_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             at_zero;

   assign at_zero = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (mrst_i)            cnt_q <= '0;
      else if (load_i)            cnt_q <= load_val_i;
      else if (wr_i)              cnt_q <= wr_val_i;
      else if (dec_i && !at_zero) cnt_q <= cnt_q - CNT_W'(1);
   end

   assign cnt_o  = cnt_q;
   assign zero_o = at_zero;
endmodule

// File: rtl/csr_bcast.sv
// Broadcast class mask and selection. Classes at or above MASK_W never match.
module csr_bcast #(
   parameter int MASK_W  = 4,
   parameter int CLASS_W = 3,
   parameter bit SEL_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_i,
   input  logic [MASK_W-1:0]  wdata_i,
   input  logic               req_i,
   input  logic [CLASS_W-1:0] class_i,
   output logic [MASK_W-1:0]  mask_o,
   output logic               sel_o
);
   localparam int IDX_W = (MASK_W > 1) ? $clog2(MASK_W) : 1;

   logic [MASK_W-1:0] mask_q;
   logic              in_range;
   logic              hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mask_q <= '0;
      else if (wr_i) mask_q <= wdata_i;
   end

   assign in_range = ({1'b0, class_i} < (CLASS_W+1)'(MASK_W));
   assign hit      = req_i && in_range && mask_q[class_i[IDX_W-1:0]];
   assign mask_o   = mask_q;

   generate
      if (SEL_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sel_o <= 1'b0;
            else        sel_o <= hit;
         end
      end else begin : g_comb
         assign sel_o = hit;
      end
   endgenerate
endmodule

// File: rtl/bus_slave_csr.sv
module bus_slave_csr
   import bus_slave_csr_pkg::*;
#(
   parameter int          DATA_W   = 32,
   parameter int          ADDR_W   = 16,
   parameter int          CNT_W    = 7,
   parameter int          MASK_W   = 4,
   parameter int          CLASS_W  = 3,
   parameter logic [31:0] CTRL_RST = 32'h0000_0040,
   parameter bit          SEL_REG  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mrst_i,
   input  logic               wr_en_i,
   input  logic [SEL_W-1:0]   reg_sel_i,
   input  logic [DATA_W-1:0]  wr_data_i,
   output logic [DATA_W-1:0]  rd_data_o,
   input  logic               xfer_dec_i,
   input  logic               evt_load_i,
   input  logic [CNT_W-1:0]   evt_count_i,
   input  logic               bcast_req_i,
   input  logic [CLASS_W-1:0] bcast_class_i,
   output logic [CNT_W-1:0]   word_count_o,
   output logic               count_zero_o,
   output logic               bcast_sel_o
);
   localparam logic [DATA_W-1:0] ADDR_WMASK = {{ADDR_W{1'b1}}, {(DATA_W-ADDR_W){1'b0}}};

   generate
      if (ADDR_W < 1 || ADDR_W > DATA_W) begin : g_bad_addr
         $error("ADDR_W must lie in 1..DATA_W");
      end
      if (CNT_W < 1 || CNT_W >= DATA_W) begin : g_bad_cnt
         $error("CNT_W must lie in 1..DATA_W-1");
      end
      if (MASK_W < 1 || MASK_W > (1 << CLASS_W) || MASK_W >= DATA_W) begin : g_bad_mask
         $error("MASK_W must fit the class field and the data word");
      end
      if (DATA_W != 32) begin : g_bad_data
         $error("DATA_W must be 32 to match CTRL_RST");
      end
   endgenerate

   logic              wr_ctrl, wr_addr, wr_cnt, wr_mask;
   logic [DATA_W-1:0] ctrl_q, addr_q;
   logic [MASK_W-1:0] mask_q;

   assign wr_ctrl = wr_en_i && (reg_sel_i == SEL_CTRL);
   assign wr_addr = wr_en_i && (reg_sel_i == SEL_ADDR);
   assign wr_cnt  = wr_en_i && (reg_sel_i == SEL_COUNT);
   assign wr_mask = wr_en_i && (reg_sel_i == SEL_MASK);

   csr_field_reg #(
      .W(DATA_W), .RST_VAL(CTRL_RST), .WMASK('1), .CLR_ON_MRST(1'b1)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .mrst_i(mrst_i),
      .wr_i(wr_ctrl), .wdata_i(wr_data_i), .q_o(ctrl_q)
   );

   csr_field_reg #(
      .W(DATA_W), .RST_VAL('0), .WMASK(ADDR_WMASK), .CLR_ON_MRST(1'b0)
   ) u_addr (
      .clk(clk), .rst_n(rst_n), .mrst_i(mrst_i),
      .wr_i(wr_addr), .wdata_i(wr_data_i), .q_o(addr_q)
   );

   csr_wcount #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .mrst_i(mrst_i),
      .load_i(evt_load_i), .load_val_i(evt_count_i),
      .wr_i(wr_cnt), .wr_val_i(wr_data_i[CNT_W-1:0]),
      .dec_i(xfer_dec_i), .cnt_o(word_count_o), .zero_o(count_zero_o)
   );

   csr_bcast #(.MASK_W(MASK_W), .CLASS_W(CLASS_W), .SEL_REG(SEL_REG)) u_bcast (
      .clk(clk), .rst_n(rst_n),
      .wr_i(wr_mask), .wdata_i(wr_data_i[MASK_W-1:0]),
      .req_i(bcast_req_i), .class_i(bcast_class_i),
      .mask_o(mask_q), .sel_o(bcast_sel_o)
   );

   always_comb begin
      unique case (reg_sel_i)
         SEL_CTRL:  rd_data_o = ctrl_q;
         SEL_ADDR:  rd_data_o = addr_q;
         SEL_COUNT: rd_data_o = {{(DATA_W-CNT_W){1'b0}}, word_count_o};
         SEL_MASK:  rd_data_o = {{(DATA_W-MASK_W){1'b0}}, mask_q};
         default:   rd_data_o = '0;
      endcase
   end
endmodule

// File: rtl/bus_slave_csr_chk.sv
module bus_slave_csr_chk
   import bus_slave_csr_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 7,
   parameter int MASK_W  = 4,
   parameter int CLASS_W = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               mrst_i,
   input logic               wr_en_i,
   input logic [SEL_W-1:0]   reg_sel_i,
   input logic               xfer_dec_i,
   input logic               evt_load_i,
   input logic [CNT_W-1:0]   evt_count_i,
   input logic               bcast_req_i,
   input logic [CLASS_W-1:0] bcast_class_i,
   input logic [CNT_W-1:0]   word_count_o,
   input logic               bcast_sel_o,
   input logic [DATA_W-1:0]  addr_q,
   input logic [MASK_W-1:0]  mask_q
);
   logic cnt_wr;
   assign cnt_wr = wr_en_i && (reg_sel_i == SEL_COUNT);

   p_mrst_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mrst_i |=> (word_count_o == '0));

   p_load_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_load_i && !mrst_i) |=> (word_count_o == $past(evt_count_i)));

   p_dec_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_dec_i && !evt_load_i && !mrst_i && !cnt_wr && word_count_o != '0)
      |=> (word_count_o == $past(word_count_o) - CNT_W'(1)));

   p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_dec_i && !evt_load_i && !mrst_i && !cnt_wr && word_count_o == '0)
      |=> (word_count_o == '0));

   p_high_class_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bcast_req_i && ({1'b0, bcast_class_i} >= (CLASS_W+1)'(MASK_W))) |=> !bcast_sel_o);

   p_no_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !bcast_req_i |=> !bcast_sel_o);

   p_addr_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mrst_i && !(wr_en_i && reg_sel_i == SEL_ADDR)) |=> (addr_q == $past(addr_q)));

   p_mask_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mrst_i && !(wr_en_i && reg_sel_i == SEL_MASK)) |=> (mask_q == $past(mask_q)));
endmodule

bind bus_slave_csr bus_slave_csr_chk #(
   .DATA_W(DATA_W), .CNT_W(CNT_W), .MASK_W(MASK_W), .CLASS_W(CLASS_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mrst_i(mrst_i), .wr_en_i(wr_en_i),
   .reg_sel_i(reg_sel_i), .xfer_dec_i(xfer_dec_i), .evt_load_i(evt_load_i),
   .evt_count_i(evt_count_i), .bcast_req_i(bcast_req_i),
   .bcast_class_i(bcast_class_i), .word_count_o(word_count_o),
   .bcast_sel_o(bcast_sel_o), .addr_q(addr_q), .mask_q(mask_q)
);

// File: tb/bus_slave_csr_tb.sv
module bus_slave_csr_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mrst_i = 1'b0;
   logic        wr_en_i = 1'b0;
   logic [1:0]  reg_sel_i = 2'd0;
   logic [31:0] wr_data_i = '0;
   logic [31:0] rd_data_o;
   logic        xfer_dec_i = 1'b0;
   logic        evt_load_i = 1'b0;
   logic [6:0]  evt_count_i = '0;
   logic        bcast_req_i = 1'b0;
   logic [2:0]  bcast_class_i = '0;
   logic [6:0]  word_count_o;
   logic        count_zero_o;
   logic        bcast_sel_o;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bus_slave_csr u_dut (
      .clk(clk), .rst_n(rst_n), .mrst_i(mrst_i), .wr_en_i(wr_en_i),
      .reg_sel_i(reg_sel_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
      .xfer_dec_i(xfer_dec_i), .evt_load_i(evt_load_i), .evt_count_i(evt_count_i),
      .bcast_req_i(bcast_req_i), .bcast_class_i(bcast_class_i),
      .word_count_o(word_count_o), .count_zero_o(count_zero_o),
      .bcast_sel_o(bcast_sel_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic write_reg(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      wr_en_i = 1'b1; reg_sel_i = sel; wr_data_i = d;
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   task automatic read_check(input string req, input logic [1:0] sel, input logic [31:0] exp);
      @(negedge clk);
      reg_sel_i = sel;
      #1;
      check(req, rd_data_o, exp);
   endtask

   task automatic pulse_mrst();
      @(negedge clk); mrst_i = 1'b1;
      @(negedge clk); mrst_i = 1'b0;
   endtask

   task automatic t_reset();
      check("R10 ctrl reset", 32'(u_dut.rd_data_o), 32'h40);
      read_check("R2 addr reset", 2'd1, 32'h0);
      read_check("R3 count reset", 2'd2, 32'h0);
      check("R5 zero flag at reset", 32'(count_zero_o), 32'h1);
      read_check("R9 mask reset", 2'd3, 32'h0);
      check("R7 sel low at reset", 32'(bcast_sel_o), 32'h0);
   endtask

   task automatic t_addr();
      write_reg(2'd1, 32'hABCD_1234);
      read_check("R1 addr low bits dropped", 2'd1, 32'hABCD_0000);
      write_reg(2'd0, 32'h1234_5678);
      read_check("R10 ctrl writable", 2'd0, 32'h1234_5678);
   endtask

   task automatic t_count_rw();
      write_reg(2'd2, 32'hFFFF_FFFF);
      read_check("R3 count width", 2'd2, 32'h7F);
      check("R3 count port", 32'(word_count_o), 32'h7F);
      check("R5 zero flag low", 32'(count_zero_o), 32'h0);
   endtask

   task automatic t_mrst();
      write_reg(2'd3, 32'h0000_000F);
      pulse_mrst();
      read_check("R10 ctrl after mrst", 2'd0, 32'h40);
      read_check("R6 count after mrst", 2'd2, 32'h0);
      read_check("R2 addr kept", 2'd1, 32'hABCD_0000);
      read_check("R9 mask kept", 2'd3, 32'hF);
      // master reset beats a same-cycle control write
      @(negedge clk);
      mrst_i = 1'b1; wr_en_i = 1'b1; reg_sel_i = 2'd0; wr_data_i = 32'hDEAD_BEEF;
      @(negedge clk);
      mrst_i = 1'b0; wr_en_i = 1'b0;
      read_check("R10 mrst over write", 2'd0, 32'h40);
   endtask

   task automatic t_load_dec();
      @(negedge clk); evt_load_i = 1'b1; evt_count_i = 7'd3;
      @(negedge clk); evt_load_i = 1'b0;
      check("R4 load", 32'(word_count_o), 32'd3);
      for (int i = 2; i >= 0; i--) begin
         @(negedge clk); xfer_dec_i = 1'b1;
         @(negedge clk); xfer_dec_i = 1'b0;
         check("R5 decrement", 32'(word_count_o), 32'(i));
      end
      check("R5 zero flag", 32'(count_zero_o), 32'h1);
      @(negedge clk); xfer_dec_i = 1'b1;
      @(negedge clk); xfer_dec_i = 1'b0;
      check("R5 saturate", 32'(word_count_o), 32'd0);
   endtask

   task automatic t_priority();
      @(negedge clk); evt_load_i = 1'b1; evt_count_i = 7'd5; xfer_dec_i = 1'b1;
      @(negedge clk); evt_load_i = 1'b0; xfer_dec_i = 1'b0;
      check("R4 load over dec", 32'(word_count_o), 32'd5);
      @(negedge clk);
      evt_load_i = 1'b1; evt_count_i = 7'd9;
      wr_en_i = 1'b1; reg_sel_i = 2'd2; wr_data_i = 32'd100;
      @(negedge clk); evt_load_i = 1'b0; wr_en_i = 1'b0;
      check("R4 load over write", 32'(word_count_o), 32'd9);
      @(negedge clk); mrst_i = 1'b1; evt_load_i = 1'b1; evt_count_i = 7'd44;
      @(negedge clk); mrst_i = 1'b0; evt_load_i = 1'b0;
      check("R6 mrst over load", 32'(word_count_o), 32'd0);
   endtask

   task automatic t_bcast();
      logic [3:0] m;
      m = 4'b0101;
      write_reg(2'd3, 32'hFFFF_FFF5);
      read_check("R7 mask width", 2'd3, 32'h5);
      for (int c = 0; c < 8; c++) begin
         @(negedge clk); bcast_req_i = 1'b1; bcast_class_i = 3'(c);
         @(negedge clk); bcast_req_i = 1'b0;
         if (c < 4) check("R7 class match", 32'(bcast_sel_o), 32'(m[c]));
         else       check("R8 high class", 32'(bcast_sel_o), 32'h0);
      end
      write_reg(2'd3, 32'hF);
      for (int c = 4; c < 8; c++) begin
         @(negedge clk); bcast_req_i = 1'b1; bcast_class_i = 3'(c);
         @(negedge clk); bcast_req_i = 1'b0;
         check("R8 high class full mask", 32'(bcast_sel_o), 32'h0);
      end
      @(negedge clk); bcast_class_i = 3'd0;
      @(negedge clk);
      check("R7 no request", 32'(bcast_sel_o), 32'h0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      reg_sel_i = 2'd0;
      #1;
      t_reset();
      t_addr();
      t_count_rw();
      t_mrst();
      t_load_dec();
      t_priority();
      t_bcast();
      repeat (2) @(negedge clk);
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end
endmodule